// File: doc/BRIEF.md
# 8-bit Accumulator Execution Core

A multi-cycle processor core that fetches variable-length instructions from a byte-wide synchronous memory and executes a fixed subset of an 8-bit accumulator instruction set. It holds two 8-bit accumulators (A, B), a 16-bit index register X, a 16-bit program counter and three flags: negative (N), zero (Z) and carry (C). Operands come from the byte after the opcode (immediate), from a two-byte absolute address (extended, high byte first), or, for branches, from a signed 8-bit offset added to the program counter.

The memory port has one address bus shared by reads and writes. Read data is valid in the cycle after the address was presented. The port has a fixed latency and no back-pressure: the core never waits, and the memory must answer every cycle. A write occurs in any cycle where the write-enable is high. Execution stops at the software-interrupt opcode 0x3F, or at any opcode outside the map, which also raises an error flag. Register and flag contents are brought out as plain status outputs so that a system can observe the result.

Top module: `cpu8_core`

## Requirements
- R1: While reset is asserted and just after its release, PC, A, B, X and N/Z/C read zero, halted and error are low, and the first fetch reads address 0x0000.
- R2: Immediate forms (two bytes, operand in the next byte) are 0x86 load A, 0x8B add, 0x89 add with carry, 0x84 AND and 0x8A OR. Each puts its result in A.
- R3: Extended forms 0xB6, 0xBB, 0xB9, 0xB4 and 0xBA perform the same operations on the byte at the 16-bit address held in the two following bytes, high byte first. Each instruction is three bytes long.
- R4: Compare (0x81 immediate, 0xB1 extended) sets the flags from A minus the operand and leaves A unchanged. C is set when the operand is unsigned-greater than A (borrow).
- R5: N is bit 7 and Z is "all zero" of the 8-bit result of every add, add-with-carry, AND, OR, load-A, compare, clear, increment and decrement. C is written only by add, add-with-carry (carry out of bit 7) and compare. All other instructions keep C.
- R6: 0xB7 writes A to the extended address and changes no register or flag.
- R7: 0x8E loads X from the two following bytes, and 0xBE loads X from the address and the address plus one. In both cases the high byte comes first, and the flags are unchanged.
- R8: 0x4F clears A and 0x5F clears B (Z=1, N=0). 0x4A decrements A with wrap-around. 0x12 only advances the PC.
- R9: 0x7C and 0x7A read the byte at the extended address and write it back incremented or decremented (modulo 256) to the same address. N/Z are set from the new value and C is kept.
- R10: 0x27 (Z=1), 0x26 (Z=0) and 0x2B (N=1) add the sign-extended offset byte to the address that follows the offset when the condition holds, and fall through otherwise.
- R11: 0x7E loads the PC with the extended address.
- R12: 0x3F raises halted with PC one past the opcode. Halted stays high until reset, with no memory write and no change of PC or registers.
- R13: An opcode outside the map raises both halted and error, with PC one past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address for read or write |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| halted | output | 1 | Core stopped |
| err | output | 1 | Stopped on an illegal opcode |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Accumulator B |
| reg_x | output | 16 | Index register X |
| reg_pc | output | 16 | Program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
In the final cycle of increment or decrement memory, the memory write-back and the N/Z flag update happen together. The bench provokes this with an FF-to-00 wrap at one address and a 00-to-FF wrap at the next. It judges the result by the two memory bytes together with the flags that remain at halt, including a C value that must survive both operations. A second overlap is the conditional branch in the cycle after a flag update: a counting loop decrements A and branches back on the fresh Z. Correctness is judged by the final A and the PC at which the core halts.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [3:0] {
    ALU_PASS, ALU_ADD, ALU_ADC, ALU_AND, ALU_OR,
    ALU_SUB, ALU_CLR, ALU_INC, ALU_DEC
  } alu_op_e;

  typedef enum logic [1:0] {M_INH, M_IMM, M_EXT, M_REL} mode_e;

  typedef enum logic [3:0] {
    K_ALU, K_CMP, K_STA, K_LDX, K_JMP, K_RMW,
    K_CLRB, K_NOP, K_SWI, K_BR, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e   kind;
    mode_e   mode;
    alu_op_e op;
  } dec_t;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_ADRH, S_ADRL, S_EXEC, S_XLO, S_HALT
  } state_e;
endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
(
  input  logic [DW-1:0] opc,
  output dec_t          dec
);
  always_comb begin
    dec = '{kind: K_BAD, mode: M_INH, op: ALU_PASS};
    case (opc)
      8'h86: dec = '{K_ALU,  M_IMM, ALU_PASS};
      8'hB6: dec = '{K_ALU,  M_EXT, ALU_PASS};
      8'h8B: dec = '{K_ALU,  M_IMM, ALU_ADD};
      8'hBB: dec = '{K_ALU,  M_EXT, ALU_ADD};
      8'h89: dec = '{K_ALU,  M_IMM, ALU_ADC};
      8'hB9: dec = '{K_ALU,  M_EXT, ALU_ADC};
      8'h84: dec = '{K_ALU,  M_IMM, ALU_AND};
      8'hB4: dec = '{K_ALU,  M_EXT, ALU_AND};
      8'h8A: dec = '{K_ALU,  M_IMM, ALU_OR};
      8'hBA: dec = '{K_ALU,  M_EXT, ALU_OR};
      8'h81: dec = '{K_CMP,  M_IMM, ALU_SUB};
      8'hB1: dec = '{K_CMP,  M_EXT, ALU_SUB};
      8'hB7: dec = '{K_STA,  M_EXT, ALU_PASS};
      8'h8E: dec = '{K_LDX,  M_IMM, ALU_PASS};
      8'hBE: dec = '{K_LDX,  M_EXT, ALU_PASS};
      8'h4F: dec = '{K_ALU,  M_INH, ALU_CLR};
      8'h5F: dec = '{K_CLRB, M_INH, ALU_CLR};
      8'h4A: dec = '{K_ALU,  M_INH, ALU_DEC};
      8'h7C: dec = '{K_RMW,  M_EXT, ALU_INC};
      8'h7A: dec = '{K_RMW,  M_EXT, ALU_DEC};
      8'h27, 8'h26, 8'h2B: dec = '{K_BR, M_REL, ALU_PASS};
      8'h7E: dec = '{K_JMP,  M_EXT, ALU_PASS};
      8'h12: dec = '{K_NOP,  M_INH, ALU_PASS};
      8'h3F: dec = '{K_SWI,  M_INH, ALU_PASS};
      default: dec = '{K_BAD, M_INH, ALU_PASS};
    endcase
  end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          n,
  output logic          z,
  output logic          c,
  output logic          c_wr
);
  logic [DW:0] wide;

  always_comb begin
    case (op)
      ALU_ADD: wide = {1'b0, x} + {1'b0, y};
      ALU_ADC: wide = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
      ALU_SUB: wide = {1'b0, x} - {1'b0, y};
      ALU_AND: wide = {1'b0, x & y};
      ALU_OR:  wide = {1'b0, x | y};
      ALU_CLR: wide = '0;
      ALU_INC: wide = {1'b0, x} + 1'b1;
      ALU_DEC: wide = {1'b0, x} - 1'b1;
      default: wide = {1'b0, y};
    endcase
  end

  assign res  = wide[DW-1:0];
  assign n    = wide[DW-1];
  assign z    = (wide[DW-1:0] == '0);
  assign c    = wide[DW];
  assign c_wr = (op == ALU_ADD) || (op == ALU_ADC) || (op == ALU_SUB);
endmodule

// File: rtl/cpu8_branch.sv
module cpu8_branch
  import cpu8_pkg::*;
(
  input  logic [DW-1:0] opc,
  input  logic          n,
  input  logic          z,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] off,
  output logic          take,
  output logic [AW-1:0] target
);
  always_comb begin
    case (opc)
      8'h27:   take = z;
      8'h26:   take = !z;
      8'h2B:   take = n;
      default: take = 1'b0;
    endcase
  end

  assign target = pc + {{(AW-DW){off[DW-1]}}, off};
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [15:0]   mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          halted,
  output logic          err,
  output logic [7:0]    reg_a,
  output logic [7:0]    reg_b,
  output logic [15:0]   reg_x,
  output logic [15:0]   reg_pc,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c
);
  state_e        state;
  logic [AW-1:0] pc, rx, ea;
  logic [DW-1:0] ra, rb, ir, ea_hi, x_hi;
  logic          fn, fz, fc, err_q;

  logic [DW-1:0] cur_opc, alu_x, alu_res;
  logic          alu_n, alu_z, alu_c, alu_cwr, br_take, flag_upd;
  logic [AW-1:0] br_target, ext_addr;
  dec_t          dec;

  assign cur_opc  = (state == S_DECODE) ? mem_rdata : ir;
  assign ext_addr = {ea_hi, mem_rdata};
  assign alu_x    = (dec.kind == K_RMW) ? mem_rdata : ra;

  cpu8_decode u_dec (.opc(cur_opc), .dec(dec));

  cpu8_alu u_alu (
    .op(dec.op), .x(alu_x), .y(mem_rdata), .cin(fc),
    .res(alu_res), .n(alu_n), .z(alu_z), .c(alu_c), .c_wr(alu_cwr)
  );

  cpu8_branch u_br (
    .opc(ir), .n(fn), .z(fz), .pc(pc), .off(mem_rdata),
    .take(br_take), .target(br_target)
  );

  // Memory address / write selection per state
  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = ra;
    case (state)
      S_ADRL: begin
        if (dec.kind != K_JMP) mem_addr = ext_addr;
        if (dec.kind == K_STA) mem_we = 1'b1;
      end
      S_EXEC: begin
        if (dec.kind == K_RMW) begin
          mem_addr  = ea;
          mem_we    = 1'b1;
          mem_wdata = alu_res;
        end else if (dec.kind == K_LDX && dec.mode == M_EXT) begin
          mem_addr = ea + AW'(1);
        end
      end
      default: mem_addr = pc;
    endcase
  end

  // Flag-writing cycles: inherent ALU ops in decode, operand ops in execute
  always_comb begin
    flag_upd = 1'b0;
    if (state == S_DECODE)
      flag_upd = (dec.kind == K_CLRB) || (dec.kind == K_ALU && dec.mode == M_INH);
    else if (state == S_EXEC)
      flag_upd = (dec.kind == K_ALU) || (dec.kind == K_CMP) || (dec.kind == K_RMW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      ra    <= '0;
      rb    <= '0;
      rx    <= '0;
      ir    <= '0;
      ea    <= '0;
      ea_hi <= '0;
      x_hi  <= '0;
      fn    <= 1'b0;
      fz    <= 1'b0;
      fc    <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (flag_upd) begin
        fn <= alu_n;
        fz <= alu_z;
        if (alu_cwr) fc <= alu_c;
      end
      case (state)
        S_FETCH: begin
          pc    <= pc + AW'(1);
          state <= S_DECODE;
        end
        S_DECODE: begin
          ir <= mem_rdata;
          case (dec.kind)
            K_SWI: state <= S_HALT;
            K_BAD: begin
              err_q <= 1'b1;
              state <= S_HALT;
            end
            K_NOP: state <= S_FETCH;
            K_CLRB: begin
              rb    <= '0;
              state <= S_FETCH;
            end
            default: begin
              if (dec.mode == M_INH) begin
                ra    <= alu_res;
                state <= S_FETCH;
              end else begin
                pc    <= pc + AW'(1);
                state <= (dec.mode == M_EXT) ? S_ADRH : S_EXEC;
              end
            end
          endcase
        end
        S_ADRH: begin
          ea_hi <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_ADRL;
        end
        S_ADRL: begin
          ea <= ext_addr;
          if (dec.kind == K_JMP) begin
            pc    <= ext_addr;
            state <= S_FETCH;
          end else if (dec.kind == K_STA) begin
            state <= S_FETCH;
          end else begin
            state <= S_EXEC;
          end
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (dec.kind)
            K_ALU: ra <= alu_res;
            K_BR:  if (br_take) pc <= br_target;
            K_LDX: begin
              x_hi  <= mem_rdata;
              if (dec.mode == M_IMM) pc <= pc + AW'(1);
              state <= S_XLO;
            end
            default: ;
          endcase
        end
        S_XLO: begin
          rx    <= {x_hi, mem_rdata};
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assign halted = (state == S_HALT);
  assign err    = err_q;
  assign reg_a  = ra;
  assign reg_b  = rb;
  assign reg_x  = rx;
  assign reg_pc = pc;
  assign flag_n = fn;
  assign flag_z = fz;
  assign flag_c = fc;
endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halted,
  input logic        err,
  input logic        mem_we,
  input logic [15:0] reg_pc,
  input logic [7:0]  reg_a,
  input logic [15:0] reg_x
);
  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(reg_pc) && $stable(reg_a) && $stable(reg_x)));

  a_r12_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  a_r13_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> halted);

  // R9 / R6: each write ends its instruction, so writes never come back to back
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

bind cpu8_core cpu8_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .err(err),
  .mem_we(mem_we), .reg_pc(reg_pc), .reg_a(reg_a), .reg_x(reg_x)
);

// File: tb/cpu8_core_tb.sv
module cpu8_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted, err;
  logic [7:0]  reg_a, reg_b;
  logic [15:0] reg_x, reg_pc;
  logic        flag_n, flag_z, flag_c;

  logic [7:0] mem [0:1023];
  int nchecks = 0;
  int nerr = 0;
  int halt_writes = 0;

  always #2 clk = ~clk;

  cpu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted), .err(err),
    .reg_a(reg_a), .reg_b(reg_b), .reg_x(reg_x), .reg_pc(reg_pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
    if (rst_n && halted && mem_we) halt_writes <= halt_writes + 1;
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a] = b;
  endtask

  task automatic go(input string req);
    int cyc;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(req, "halt reached", {15'd0, halted}, 16'd1);
  endtask

  task automatic t_imm();
    clr_mem();
    put(0, 8'h86); put(1, 8'h7F); put(2, 8'h8B); put(3, 8'h01);
    put(4, 8'h84); put(5, 8'hF0); put(6, 8'h8A); put(7, 8'h0F);
    put(8, 8'h3F);
    go("R2");
    chk("R2", "A after imm chain", {8'h0, reg_a}, 16'h008F);
    chk("R5", "N after OR", {15'd0, flag_n}, 16'd1);
    chk("R5", "C after 7F+01", {15'd0, flag_c}, 16'd0);
    chk("R12", "PC after SWI", reg_pc, 16'h0009);
    chk("R13", "err after SWI", {15'd0, err}, 16'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "PC in reset", reg_pc, 16'h0000);
    chk("R1", "A in reset", {8'h0, reg_a}, 16'h0000);
    chk("R1", "X in reset", reg_x, 16'h0000);
    chk("R1", "flags in reset", {13'd0, flag_n, flag_z, flag_c}, 16'h0000);
    chk("R1", "halted in reset", {15'd0, halted}, 16'd0);
    rst_n = 1'b1;
    chk("R1", "first fetch address", mem_addr, 16'h0000);
  endtask

  task automatic t_adc();
    clr_mem();
    put(0, 8'h86); put(1, 8'hFF); put(2, 8'h8B); put(3, 8'h01);
    put(4, 8'h89); put(5, 8'h05); put(6, 8'h3F);
    go("R2");
    chk("R2", "A after adc", {8'h0, reg_a}, 16'h0006);
    chk("R5", "C after adc", {15'd0, flag_c}, 16'd0);
    chk("R5", "Z after adc", {15'd0, flag_z}, 16'd0);
  endtask

  task automatic t_ext();
    clr_mem();
    put(16'h200, 8'h33); put(16'h201, 8'h0F);
    put(0, 8'hB6); put(1, 8'h02); put(2, 8'h00);
    put(3, 8'hBB); put(4, 8'h02); put(5, 8'h01);
    put(6, 8'hB4); put(7, 8'h02); put(8, 8'h01);
    put(9, 8'hBA); put(10, 8'h02); put(11, 8'h00);
    put(12, 8'hB9); put(13, 8'h02); put(14, 8'h01);
    put(15, 8'hB7); put(16, 8'h03); put(17, 8'h00);
    put(18, 8'h3F);
    go("R3");
    chk("R3", "A after ext chain", {8'h0, reg_a}, 16'h0042);
    chk("R6", "stored byte", {8'h0, mem[16'h300]}, 16'h0042);
    chk("R12", "PC after ext prog", reg_pc, 16'h0013);
  endtask

  task automatic t_sta_flags();
    clr_mem();
    put(0, 8'h86); put(1, 8'hFF); put(2, 8'h8B); put(3, 8'h01);
    put(4, 8'h8A); put(5, 8'h01);
    put(6, 8'hB7); put(7, 8'h03); put(8, 8'h10); put(9, 8'h3F);
    go("R6");
    chk("R6", "stored A", {8'h0, mem[16'h310]}, 16'h0001);
    chk("R6", "C kept over OR and store", {15'd0, flag_c}, 16'd1);
    chk("R6", "Z after store", {15'd0, flag_z}, 16'd0);
  endtask

  task automatic t_cmp();
    clr_mem();
    put(0, 8'h86); put(1, 8'h10); put(2, 8'h81); put(3, 8'h20); put(4, 8'h3F);
    go("R4");
    chk("R4", "A after cmp", {8'h0, reg_a}, 16'h0010);
    chk("R4", "C borrow", {15'd0, flag_c}, 16'd1);
    chk("R4", "N of 10-20", {15'd0, flag_n}, 16'd1);
    clr_mem();
    put(16'h200, 8'h10);
    put(0, 8'h86); put(1, 8'h10); put(2, 8'hB1); put(3, 8'h02); put(4, 8'h00);
    put(5, 8'h3F);
    go("R4");
    chk("R4", "Z equal ext", {15'd0, flag_z}, 16'd1);
    chk("R4", "C no borrow", {15'd0, flag_c}, 16'd0);
    chk("R4", "A kept ext", {8'h0, reg_a}, 16'h0010);
  endtask

  task automatic t_ldx();
    clr_mem();
    put(0, 8'h8E); put(1, 8'h12); put(2, 8'h34); put(3, 8'h3F);
    go("R7");
    chk("R7", "X immediate", reg_x, 16'h1234);
    chk("R7", "PC after 8E", reg_pc, 16'h0004);
    clr_mem();
    put(16'h200, 8'hAB); put(16'h201, 8'hCD);
    put(0, 8'hBE); put(1, 8'h02); put(2, 8'h00); put(3, 8'h3F);
    go("R7");
    chk("R7", "X extended", reg_x, 16'hABCD);
    chk("R7", "Z untouched by LDX", {15'd0, flag_z}, 16'd0);
  endtask

  task automatic t_inh();
    clr_mem();
    put(0, 8'h86); put(1, 8'h02); put(2, 8'h4A); put(3, 8'h12); put(4, 8'h3F);
    go("R8");
    chk("R8", "A after deca", {8'h0, reg_a}, 16'h0001);
    chk("R8", "PC after nop", reg_pc, 16'h0005);
    clr_mem();
    put(0, 8'h86); put(1, 8'h80); put(2, 8'h5F); put(3, 8'h3F);
    go("R8");
    chk("R8", "A kept by clrb", {8'h0, reg_a}, 16'h0080);
    chk("R8", "B cleared", {8'h0, reg_b}, 16'h0000);
    chk("R8", "Z/N after clrb", {14'd0, flag_z, flag_n}, 16'h0002);
    clr_mem();
    put(0, 8'h86); put(1, 8'h7F); put(2, 8'h4F); put(3, 8'h4A); put(4, 8'h3F);
    go("R8");
    chk("R8", "A after clra+deca wrap", {8'h0, reg_a}, 16'h00FF);
    chk("R5", "N after wrap", {15'd0, flag_n}, 16'd1);
  endtask

  task automatic t_rmw();
    clr_mem();
    put(16'h200, 8'hFF); put(16'h201, 8'h00);
    put(0, 8'h86); put(1, 8'hFF); put(2, 8'h8B); put(3, 8'h01);
    put(4, 8'h7C); put(5, 8'h02); put(6, 8'h00);
    put(7, 8'h7A); put(8, 8'h02); put(9, 8'h01);
    put(10, 8'h3F);
    go("R9");
    chk("R9", "inc wrap", {8'h0, mem[16'h200]}, 16'h0000);
    chk("R9", "dec wrap", {8'h0, mem[16'h201]}, 16'h00FF);
    chk("R9", "N/Z after dec", {14'd0, flag_n, flag_z}, 16'h0002);
    chk("R9", "C kept", {15'd0, flag_c}, 16'd1);
  endtask

  task automatic t_branch();
    clr_mem();
    put(0, 8'h86); put(1, 8'h00);
    put(2, 8'h27); put(3, 8'h02);
    put(4, 8'h86); put(5, 8'h55);
    put(6, 8'h26); put(7, 8'h02);
    put(8, 8'h86); put(9, 8'h80);
    put(10, 8'h2B); put(11, 8'h02);
    put(12, 8'h86); put(13, 8'h66);
    put(14, 8'h3F);
    go("R10");
    chk("R10", "A after forward branches", {8'h0, reg_a}, 16'h0080);
    chk("R10", "PC after forward branches", reg_pc, 16'h000F);
    clr_mem();
    put(0, 8'h86); put(1, 8'h03); put(2, 8'h4A); put(3, 8'h26); put(4, 8'hFD);
    put(5, 8'h3F);
    go("R10");
    chk("R10", "A after backward loop", {8'h0, reg_a}, 16'h0000);
    chk("R10", "PC after loop", reg_pc, 16'h0006);
  endtask

  task automatic t_jmp();
    clr_mem();
    put(0, 8'h7E); put(1, 8'h00); put(2, 8'h10); put(3, 8'h3F);
    put(16'h10, 8'h86); put(16'h11, 8'h77); put(16'h12, 8'h3F);
    go("R11");
    chk("R11", "A at jump target", {8'h0, reg_a}, 16'h0077);
    chk("R11", "PC after jump", reg_pc, 16'h0013);
  endtask

  task automatic t_halt_hold();
    logic [15:0] pc0;
    pc0 = reg_pc;
    repeat (20) @(negedge clk);
    chk("R12", "halted held", {15'd0, halted}, 16'd1);
    chk("R12", "PC frozen", reg_pc, pc0);
    chk("R12", "no writes while halted", halt_writes[15:0], 16'd0);
  endtask

  task automatic t_illegal();
    clr_mem();
    put(0, 8'h86); put(1, 8'h42); put(2, 8'h01); put(3, 8'h86); put(4, 8'h99);
    go("R13");
    chk("R13", "err set", {15'd0, err}, 16'd1);
    chk("R13", "A unchanged", {8'h0, reg_a}, 16'h0042);
    chk("R13", "PC past bad opcode", reg_pc, 16'h0003);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    t_imm();
    t_reset();
    t_adc();
    t_ext();
    t_sta_flags();
    t_cmp();
    t_ldx();
    t_inh();
    t_rmw();
    t_halt_hold();
    t_branch();
    t_jmp();
    t_illegal();
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule